// File: doc/BRIEF.md
# Management Bus Master with Register Access

This block is a register-programmed master for the two-wire PHY management bus. Software sets a frame-type bit, a PHY address, a register or device number and a 16-bit data word through a simple single-cycle register port. It then writes a command word that carries a go bit and an access code. The block builds the complete serial frame and clocks it out on MDC, with a tri-stated MDIO pin. Software polls a busy bit until the frame is done and, after a read, fetches the captured word from a read-data register.

Both short-form frames (register number in the frame) and extended-form frames are supported. The extended form uses one data register for two jobs. In an address frame that register supplies the 16-bit register pointer. In a write frame it supplies the data. MDC is a division of the 100 MHz source clock. The default half-period of 20 source cycles gives 2.5 MHz.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and `mdio_oe` is low.
- R2: Writes are held and read back at fixed offsets. Offset 0x40 holds the frame type in bit 8 (0 short form, 1 extended form). Offset 0x44 holds the PHY address in bits 12:8 and the register/device number in bits 4:0. Offset 0x48 holds the data word in bits 15:0. Offset 0x4C returns the last read word in bits 15:0. Offset 0x50 returns busy in bit 16. All other bits and offsets read zero.
- R3: A write to 0x50 with bit 8 set and a valid access code in bits 1:0 makes bit 16 read 1 from the next cycle. It stays 1 for exactly 128*DIV_HALF+1 cycles.
- R4: MDC idles low. During a frame it has a period of 2*DIV_HALF source cycles, starts with a low half and makes 64 rising edges. The frame ends on a falling edge.
- R5: Every frame is sent MSB first in this order: 32 ones, 2 start bits, 2 opcode bits, 5 PHY bits, 5 register/device bits, 2 turnaround bits and 16 data bits. A short-form frame uses start 01 and opcode 10 for code 0 (read) or 01 for code 1 (write). Its write turnaround is 10 and its data comes from offset 0x48.
- R6: An extended-form frame uses start 00. Its opcode is 00 for code 0 (address), 01 for code 1 (write) and 11 for code 2 (read). In address and write frames the 16-bit field is the word at offset 0x48.
- R7: In a read frame `mdio_oe` falls at the first turnaround bit (frame bit 46) and stays low to the end. The 16 data bits are sampled on rising MDC edges, MSB first. They appear at offset 0x4C once busy clears. Non-read frames leave offset 0x4C unchanged.
- R8: While the master drives, `mdio_o` changes only at a falling edge of MDC.
- R9: A command written while busy is ignored. The running frame keeps its length and content, and no second frame follows.
- R10: Invalid commands start nothing, and busy stays 0. These are a command without bit 8, short-form codes 2 and 3, and extended-form code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable, low means released |
| mdio_i | input | 1 | Serial data in |

## Verification
A bit counter or shift register that is off by one shows on the pins within one MDC half-period. The bench predicts MDC, the output enable and every driven bit on every source clock, so the first wrong bit is caught at once. A frame that ends early or late shows in the busy bit. Its length is counted to the exact cycle. A wrong capture window or bit order in a read shows as a wrong word at offset 0x4C right after busy clears. A lost or extra command shows as a busy bit or MDC toggle where the model has none.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_ADDR  = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int MODE_EXT_BIT = 8;
  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_BUSY_BIT = 16;

  typedef struct packed {
    logic                 rd;
    logic [FRAME_LEN-1:0] bits;
  } frame_t;

  function automatic logic code_ok(logic ext, logic [1:0] code);
    return ext ? (code != 2'd3) : (code[1] == 1'b0);
  endfunction

  function automatic logic code_rd(logic ext, logic [1:0] code);
    return ext ? (code == 2'd2) : (code == 2'd0);
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    logic ext, logic [1:0] code, logic [4:0] phy, logic [4:0] ra, logic [15:0] word);
    logic [1:0]  st;
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] fld;
    st = ext ? 2'b00 : 2'b01;
    if (ext) begin
      op = (code == 2'd2) ? 2'b11 : {1'b0, code[0]};
    end else begin
      op = code[0] ? 2'b01 : 2'b10;
    end
    if (code_rd(ext, code)) begin
      ta  = 2'b11;
      fld = 16'hFFFF;
    end else begin
      ta  = 2'b10;
      fld = word;
    end
    return {32'hFFFF_FFFF, st, op, phy, ra, ta, fld};
  endfunction

endpackage

// File: rtl/mgmt_mdc_div.sv
module mgmt_mdc_div #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int            CW   = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap      = run && (cnt_q == LAST);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R4: the clock returns low once the frame engine stops running it
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mgmt_frame.sv
module mgmt_frame
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  frame_t               frame,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdc,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 done,
  output logic [15:0]          cap_data,
  output logic                 mdio_o,
  output logic                 mdio_oe
);

  localparam int IW = $clog2(FRAME_LEN);

  logic                 active_q, active_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 isrd_q, isrd_d;
  logic [15:0]          cap_q, cap_d;
  logic                 last_bit;

  assign last_bit = (idx_q == IW'(FRAME_LEN - 1));
  assign done     = active_q && fall_tick && last_bit;
  assign active   = active_q;
  assign cap_data = cap_q;
  assign mdio_o   = sh_q[FRAME_LEN-1];
  assign mdio_oe  = active_q && !(isrd_q && (idx_q >= IW'(TA_POS)));

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    isrd_d   = isrd_q;
    cap_d    = cap_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      sh_d     = frame.bits;
      isrd_d   = frame.rd;
    end else if (active_q && fall_tick) begin
      if (last_bit) begin
        active_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
      end
    end
    if (active_q && rise_tick && isrd_q && (idx_q >= IW'(DATA_POS))) begin
      cap_d = {cap_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      isrd_q   <= 1'b0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      isrd_q   <= isrd_d;
      cap_q    <= cap_d;
    end
  end

  // R5: a frame opens with the master driving a preamble one
  p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (mdio_oe && mdio_o));

  // R8: the serial output moves only together with a falling MDC
  p_out_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$stable(mdio_o)) |-> $fell(mdc));

  // R4: a frame closes on a falling MDC
  p_end_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $fell(mdc));

endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_active,
  input  logic              eng_done,
  input  logic [15:0]       eng_data,
  output logic              start,
  output frame_t            frame
);

  logic        ext_q, ext_d;
  logic [4:0]  phy_q, phy_d;
  logic [4:0]  ra_q, ra_d;
  logic [15:0] wd_q, wd_d;
  logic [15:0] rd_q, rd_d;
  logic        start_q, start_d;
  frame_t      frm_q, frm_d;
  logic        busy;
  logic        cmd_fire;
  logic [1:0]  code;
  logic        unused_wbits;

  assign busy         = start_q || eng_active;
  assign code         = reg_wdata[1:0];
  assign start        = start_q;
  assign frame        = frm_q;
  assign unused_wbits = ^reg_wdata[DATA_W-1:16];

  always_comb begin
    ext_d    = ext_q;
    phy_d    = phy_q;
    ra_d     = ra_q;
    wd_d     = wd_q;
    rd_d     = rd_q;
    frm_d    = frm_q;
    cmd_fire = 1'b0;
    if (reg_we) begin
      unique case (reg_addr)
        ADDR_W'(OFS_MODE):  ext_d = reg_wdata[MODE_EXT_BIT];
        ADDR_W'(OFS_ADDR): begin
          phy_d = reg_wdata[12:8];
          ra_d  = reg_wdata[4:0];
        end
        ADDR_W'(OFS_WDATA): wd_d = reg_wdata[15:0];
        ADDR_W'(OFS_CMD):   cmd_fire = reg_wdata[CMD_GO_BIT] && !busy && code_ok(ext_q, code);
        default: ;
      endcase
    end
    start_d = cmd_fire;
    if (cmd_fire) begin
      frm_d.rd   = code_rd(ext_q, code);
      frm_d.bits = build_frame(ext_q, code, phy_q, ra_q, wd_q);
    end
    if (eng_done && frm_q.rd) begin
      rd_d = eng_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      phy_q   <= '0;
      ra_q    <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      start_q <= 1'b0;
      frm_q   <= '0;
    end else begin
      ext_q   <= ext_d;
      phy_q   <= phy_d;
      ra_q    <= ra_d;
      wd_q    <= wd_d;
      rd_q    <= rd_d;
      start_q <= start_d;
      frm_q   <= frm_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(OFS_MODE):  reg_rdata[MODE_EXT_BIT] = ext_q;
      ADDR_W'(OFS_ADDR): begin
        reg_rdata[12:8] = phy_q;
        reg_rdata[4:0]  = ra_q;
      end
      ADDR_W'(OFS_WDATA): reg_rdata[15:0] = wd_q;
      ADDR_W'(OFS_RDATA): reg_rdata[15:0] = rd_q;
      ADDR_W'(OFS_CMD):   reg_rdata[CMD_BUSY_BIT] = busy;
      default: ;
    endcase
  end

  // R9: no new frame is launched while the engine is still shifting
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> !start_q);

  // R3: an accepted command puts the engine to work on the next cycle
  p_start_then_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> eng_active);

endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIV_HALF = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic        start;
  frame_t      frame;
  logic        eng_active;
  logic        eng_done;
  logic [15:0] eng_data;
  logic        rise_tick;
  logic        fall_tick;

  mgmt_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_active (eng_active),
    .eng_done   (eng_done),
    .eng_data   (eng_data),
    .start      (start),
    .frame      (frame)
  );

  mgmt_mdc_div #(
    .DIV_HALF (DIV_HALF)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_active),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame     (frame),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .done      (eng_done),
    .cap_data  (eng_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

endmodule

// File: tb/test_mgmt_bus_master.sv
module test_mgmt_bus_master;

  localparam int CLK_PERIOD = 10;
  localparam int D          = 3;
  localparam int FRAME_CYC  = 128 * D;

  logic        clk;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks;
  int errors;
  int cycles;

  mgmt_bus_master #(.ADDR_W(8), .DATA_W(32), .DIV_HALF(D)) i_mgmt_bus_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (we),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = !clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_ext;
  int        m_phy, m_ra, m_wd, m_rd, m_resp;
  bit        m_pend, m_act, m_read;
  int        m_t;
  bit        m_bits[$];
  bit        m_busy_now;

  task automatic put(int v, int n);
    for (int i = n - 1; i >= 0; i--) m_bits.push_back(bit'((v >> i) & 1));
  endtask

  task automatic model_frame(int code);
    int op;
    m_bits.delete();
    for (int i = 0; i < 32; i++) m_bits.push_back(1'b1);
    put(m_ext ? 0 : 1, 2);
    if (m_ext) op = (code == 0) ? 0 : (code == 1) ? 1 : 3;
    else       op = (code == 0) ? 2 : 1;
    put(op, 2);
    put(m_phy, 5);
    put(m_ra, 5);
    m_read = m_ext ? (code == 2) : (code == 0);
    put(m_read ? 3 : 2, 2);
    put(m_read ? 16'hFFFF : m_wd, 16);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ext = 0; m_phy = 0; m_ra = 0; m_wd = 0; m_rd = 0;
      m_pend = 0; m_act = 0; m_t = 0; m_read = 0;
    end else begin
      m_busy_now = m_pend || m_act;
      if (m_act) begin
        m_t++;
        if (m_t == FRAME_CYC) begin
          m_act = 0;
          if (m_read) m_rd = m_resp;
        end
      end
      if (m_pend) begin
        m_pend = 0;
        m_act  = 1;
        m_t    = 0;
      end
      if (we) begin
        case (addr)
          8'h40: m_ext = wdata[8];
          8'h44: begin m_phy = int'(wdata[12:8]); m_ra = int'(wdata[4:0]); end
          8'h48: m_wd = int'(wdata[15:0]);
          8'h50: if (wdata[8] && !m_busy_now &&
                     (m_ext ? (wdata[1:0] != 2'd3) : (wdata[1] == 1'b0))) begin
                   m_pend = 1;
                   model_frame(int'(wdata[1:0]));
                 end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rdata(logic [7:0] a);
    case (a)
      8'h40: return {23'd0, m_ext, 8'd0};
      8'h44: return 32'((m_phy << 8) | m_ra);
      8'h48: return 32'(m_wd);
      8'h4C: return 32'(m_rd);
      8'h50: return {15'd0, (m_pend || m_act), 16'd0};
      default: return 32'd0;
    endcase
  endfunction

  // ---------------- per-clock comparison and PHY responder ----------------
  bit prev_oe, prev_o, prev_mdc;

  always @(negedge clk) begin
    if (rst_n) begin
      int  idx;
      bit  e_mdc, e_oe;
      idx   = m_t / (2 * D);
      e_mdc = m_act && (((m_t / D) % 2) == 1);
      e_oe  = m_act && !(m_read && idx >= 46);
      chk(mdc == e_mdc, "R4 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R7 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe && mdio_oe)
        chk(mdio_o == m_bits[idx], "R5 R6 frame bit", 32'(mdio_o), 32'(m_bits[idx]));
      chk(rdata == exp_rdata(addr), "R2 register read", rdata, exp_rdata(addr));
      if (mdio_oe && prev_oe && (mdio_o != prev_o))
        chk(prev_mdc && !mdc, "R8 output change at falling mdc", 32'(mdc), 32'd0);
      mdio_i = (m_act && m_read && idx >= 48) ? 1'(m_resp >> (63 - idx)) : 1'b1;
    end
    prev_oe  = mdio_oe;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk); #1;
    addr = a;
    #1;
    chk(rdata == e, tag, rdata, e);
  endtask

  task automatic run_cmd(logic [31:0] c, string tag);
    int n;
    wr(8'h50, c);
    n = 0;
    #1;
    while (rdata[16]) begin
      n++;
      @(negedge clk); #2;
    end
    chk(n == FRAME_CYC + 1, tag, 32'(n), 32'(FRAME_CYC + 1));
  endtask

  task automatic idle_for(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      addr = 8'h50;
      #1;
      chk(!rdata[16] && !mdc && !mdio_oe, tag, rdata, 32'd0);
    end
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; we = 1'b0; addr = 8'h00; wdata = '0; mdio_i = 1'b1;
    m_resp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(!mdc && !mdio_oe, "R1 pins idle", {30'd0, mdc, mdio_oe}, 32'd0);
    rd_chk(8'h40, 32'd0, "R1 mode");
    rd_chk(8'h44, 32'd0, "R1 address");
    rd_chk(8'h48, 32'd0, "R1 write data");
    rd_chk(8'h4C, 32'd0, "R1 read data");
    rd_chk(8'h50, 32'd0, "R1 command");

    // R2: field readback
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk(8'h40, 32'h0000_0100, "R2 mode bit");
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk(8'h44, 32'h0000_1F1F, "R2 address fields");
    wr(8'h48, 32'h1234_ABCD);
    rd_chk(8'h48, 32'h0000_ABCD, "R2 data word");
    rd_chk(8'h5C, 32'd0, "R2 unmapped offset");

    // R5: short-form write then read
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0000_0311);
    wr(8'h48, 32'h0000_BEEF);
    run_cmd(32'h101, "R3 short write busy length");
    rd_chk(8'h4C, 32'd0, "R7 write leaves read data");
    m_resp = 16'h5A3C;
    wr(8'h44, 32'h0000_1501);
    run_cmd(32'h100, "R3 short read busy length");
    rd_chk(8'h4C, 32'h0000_5A3C, "R7 short read word");

    // R6: extended-form address, write, read
    wr(8'h40, 32'h100);
    wr(8'h44, 32'h0000_0A07);
    wr(8'h48, 32'h0000_8001);
    run_cmd(32'h100, "R6 address frame");
    wr(8'h48, 32'h0000_C35A);
    run_cmd(32'h101, "R6 write frame");
    rd_chk(8'h4C, 32'h0000_5A3C, "R7 ext write leaves read data");
    m_resp = 16'h1234;
    run_cmd(32'h102, "R6 read frame");
    rd_chk(8'h4C, 32'h0000_1234, "R7 ext read word");

    // R9: command while busy
    wr(8'h40, 32'h0);
    wr(8'h48, 32'h0000_00FF);
    wr(8'h50, 32'h101);
    repeat (10) @(negedge clk);
    m_resp = 16'hFFFF;
    wr(8'h50, 32'h100);
    while (m_pend || m_act) @(negedge clk);
    idle_for(3 * FRAME_CYC / 2, "R9 no second frame");
    rd_chk(8'h4C, 32'h0000_1234, "R9 read data untouched");

    // R10: invalid commands
    wr(8'h50, 32'h102);
    idle_for(8, "R10 short code 2");
    wr(8'h50, 32'h103);
    idle_for(8, "R10 short code 3");
    wr(8'h40, 32'h100);
    wr(8'h50, 32'h103);
    idle_for(8, "R10 extended code 3");
    wr(8'h50, 32'h001);
    idle_for(8, "R10 no go bit");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial cycles = 0;

endmodule